// File: doc/BRIEF.md
# Bypass Ring Steering Unit

This unit sits beside a node's network router. It lets the node stay on a one-way ring of bypass links while the router is powered down. Every node has one bypass input from its upstream neighbour and one bypass output toward its downstream neighbour. Chained together, these links form a single ring that reaches every node whatever the power state of the routers.

While the router is powered, the unit passes traffic straight through:

- the ring input feeds the router's ring-side input;
- the router's ring-side output drives the ring output;
- the network interface's injection and ejection streams connect to the router's local ports.

When the dark request is raised and no packet is in flight, the unit switches to steering mode and the router side goes quiet. In steering mode:

- Packets arriving on the ring whose head destination equals this node are ejected to the network interface.
- Packets arriving on the ring for any other node are forwarded unchanged to the ring output.
- Packets from the network interface are injected onto the ring output.

Transit traffic wins the ring output at a packet boundary. Once a source owns the output, it keeps it until that packet's tail. Packets therefore never interleave. Readiness flows back combinationally through whichever path is selected.

The unit works on flits with valid/ready handshakes. A flit is `{head, tail, dest, payload}`:

- bit `FLIT_W-1` is the head marker;
- bit `FLIT_W-2` is the tail marker;
- the next `NODE_W` bits hold the destination node;
- the low `DATA_W` bits are payload.

A single-flit packet has both markers set.

Top module: `ring_bypass_steer`

## Requirements
- R1: After reset the unit is in router mode: a ring-input flit appears on `rtr_rin_valid` and not on `ej_valid` or `rout_valid`, even if its destination equals `NODE_ID`.
- R2: In router mode, the four paths ring-in to router-in, router-out to ring-out, injection to router local input, and router local output to ejection carry flits unchanged.
- R3: In steering mode, a packet on the ring input whose head destination field (bits `FLIT_W-3` down to `FLIT_W-2-NODE_W`) equals `NODE_ID` is delivered, all flits and unchanged, on the ejection port.
- R4: In steering mode, a packet on the ring input whose head destination differs from `NODE_ID` is forwarded, all flits and unchanged, on the ring output.
- R5: In steering mode, packets from the injection port are delivered unchanged on the ring output.
- R6: Once a source is granted the ring output, its flits hold and continue until its tail flit is accepted. A waiting packet from the other source does not interleave.
- R7: When a transit packet and a local packet both request an idle ring output in the same cycle, the transit packet goes first.
- R8: A change of `dark_req` takes effect only when no packet is mid-transfer on the ring input, ring output, injection or ejection port. In steering mode, `rtr_rin_valid`, `rtr_inj_valid`, `rtr_rout_ready` and `rtr_ej_ready` are all 0.
- R9: Ready is combinational along the selected path: in steering mode, for a flit headed for ejection, `rin_ready` equals `ej_ready` in the same cycle.
- R10: Bit `FLIT_W-1` marks a head and bit `FLIT_W-2` marks a tail. A flit with both set is a complete one-flit packet and frees the path at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dark_req | input | 1 | 1 requests steering mode (router powered down) |
| rin_valid | input | 1 | Ring input flit valid |
| rin_flit | input | FLIT_W | Ring input flit |
| rin_ready | output | 1 | Ring input ready |
| rout_valid | output | 1 | Ring output flit valid |
| rout_flit | output | FLIT_W | Ring output flit |
| rout_ready | input | 1 | Ring output ready from downstream |
| inj_valid | input | 1 | Injection flit valid from network interface |
| inj_flit | input | FLIT_W | Injection flit |
| inj_ready | output | 1 | Injection ready |
| ej_valid | output | 1 | Ejection flit valid to network interface |
| ej_flit | output | FLIT_W | Ejection flit |
| ej_ready | input | 1 | Ejection ready |
| rtr_rin_valid | output | 1 | Valid toward router ring-side input |
| rtr_rin_flit | output | FLIT_W | Flit toward router ring-side input |
| rtr_rin_ready | input | 1 | Router ring-side input ready |
| rtr_rout_valid | input | 1 | Router ring-side output valid |
| rtr_rout_flit | input | FLIT_W | Router ring-side output flit |
| rtr_rout_ready | output | 1 | Ready toward router ring-side output |
| rtr_inj_valid | output | 1 | Valid toward router local input |
| rtr_inj_flit | output | FLIT_W | Flit toward router local input |
| rtr_inj_ready | input | 1 | Router local input ready |
| rtr_ej_valid | input | 1 | Router local output valid |
| rtr_ej_flit | input | FLIT_W | Router local output flit |
| rtr_ej_ready | output | 1 | Ready toward router local output |

## Verification
The bench builds the unit with `NODE_W=3`, `DATA_W=8` and `NODE_ID=5`. This gives 13-bit flits and eight addresses, so both local and foreign destinations are easy to produce. Payloads count upward, so any flit that is dropped, duplicated or reordered shows up in the scoreboard.

Sink readies follow a stall pattern that stops two cycles in three. This keeps packets in flight long enough to test mode changes in mid-packet and ownership of the ring output under contention.

// File: rtl/ring_bypass_pkg.sv
package ring_bypass_pkg;

  typedef enum logic [1:0] {
    OWN_NONE    = 2'd0,
    OWN_TRANSIT = 2'd1,
    OWN_LOCAL   = 2'd2
  } out_owner_e;

  typedef enum logic {
    RT_FORWARD = 1'b0,
    RT_EJECT   = 1'b1
  } rx_route_e;

  localparam int N_STREAMS = 4;
  localparam int S_RIN  = 0;
  localparam int S_ROUT = 1;
  localparam int S_INJ  = 2;
  localparam int S_EJ   = 3;

endpackage

// File: rtl/rbs_pkt_track.sv
// Packet-boundary tracker for one valid/ready stream.
module rbs_pkt_track (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic tail,
  output logic busy,
  output logic busy_d
);

  logic busy_q;

  // A non-tail flit leaves the stream mid-packet; a tail closes it (R10).
  always_comb begin
    busy_d = busy_q;
    if (fire) busy_d = !tail;
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_d;
  end

  assign busy = busy_q;

endmodule

// File: rtl/rbs_rx_route.sv
// Decides eject or forward on the head flit and holds the choice to the tail.
module rbs_rx_route
  import ring_bypass_pkg::*;
#(
  parameter int NODE_W  = 3,
  parameter int NODE_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_busy,
  input  logic              fire,
  input  logic [NODE_W-1:0] dest,
  output rx_route_e         route
);

  localparam logic [NODE_W-1:0] MY_ID = NODE_ID[NODE_W-1:0];

  rx_route_e route_q;
  rx_route_e head_route;

  assign head_route = (dest == MY_ID) ? RT_EJECT : RT_FORWARD;
  assign route      = in_busy ? route_q : head_route;

  always_ff @(posedge clk) begin
    if (rst)                    route_q <= RT_FORWARD;
    else if (fire && !in_busy)  route_q <= head_route;
  end

endmodule

// File: rtl/rbs_out_arb.sv
// Ring-output owner: transit first at a boundary, locked until tail.
module rbs_out_arb
  import ring_bypass_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tr_req,
  input  logic       loc_req,
  input  logic       fire,
  input  logic       tail,
  output out_owner_e owner,
  output out_owner_e owner_nxt
);

  out_owner_e owner_q;

  always_comb begin
    if (!en)                      owner = OWN_NONE;
    else if (owner_q != OWN_NONE) owner = owner_q;
    else if (tr_req)              owner = OWN_TRANSIT;
    else if (loc_req)             owner = OWN_LOCAL;
    else                          owner = OWN_NONE;
  end

  always_comb begin
    if (!en || (fire && tail)) owner_nxt = OWN_NONE;
    else                       owner_nxt = owner;
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner_nxt;
  end

endmodule

// File: rtl/ring_bypass_steer.sv
module ring_bypass_steer
  import ring_bypass_pkg::*;
#(
  parameter int NODE_W  = 3,
  parameter int DATA_W  = 8,
  parameter int NODE_ID = 0,
  localparam int FLIT_W = 2 + NODE_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dark_req,
  input  logic              rin_valid,
  input  logic [FLIT_W-1:0] rin_flit,
  output logic              rin_ready,
  output logic              rout_valid,
  output logic [FLIT_W-1:0] rout_flit,
  input  logic              rout_ready,
  input  logic              inj_valid,
  input  logic [FLIT_W-1:0] inj_flit,
  output logic              inj_ready,
  output logic              ej_valid,
  output logic [FLIT_W-1:0] ej_flit,
  input  logic              ej_ready,
  output logic              rtr_rin_valid,
  output logic [FLIT_W-1:0] rtr_rin_flit,
  input  logic              rtr_rin_ready,
  input  logic              rtr_rout_valid,
  input  logic [FLIT_W-1:0] rtr_rout_flit,
  output logic              rtr_rout_ready,
  output logic              rtr_inj_valid,
  output logic [FLIT_W-1:0] rtr_inj_flit,
  input  logic              rtr_inj_ready,
  input  logic              rtr_ej_valid,
  input  logic [FLIT_W-1:0] rtr_ej_flit,
  output logic              rtr_ej_ready
);

  localparam int TAIL_BIT = FLIT_W - 2;
  localparam int DEST_HI  = FLIT_W - 3;

  // 1 = steering mode (router dark), 0 = router mode.
  logic       mode_q;
  logic       quiet;
  rx_route_e  route;
  out_owner_e owner, owner_nxt;
  logic       tr_req;

  logic [N_STREAMS-1:0] s_fire, s_tail, s_busy, s_busy_d;

  assign s_fire[S_RIN]  = rin_valid  && rin_ready;
  assign s_fire[S_ROUT] = rout_valid && rout_ready;
  assign s_fire[S_INJ]  = inj_valid  && inj_ready;
  assign s_fire[S_EJ]   = ej_valid   && ej_ready;
  assign s_tail[S_RIN]  = rin_flit[TAIL_BIT];
  assign s_tail[S_ROUT] = rout_flit[TAIL_BIT];
  assign s_tail[S_INJ]  = inj_flit[TAIL_BIT];
  assign s_tail[S_EJ]   = ej_flit[TAIL_BIT];

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_track
    rbs_pkt_track u_trk (
      .clk    (clk),
      .rst    (rst),
      .fire   (s_fire[g]),
      .tail   (s_tail[g]),
      .busy   (s_busy[g]),
      .busy_d (s_busy_d[g])
    );
  end

  rbs_rx_route #(.NODE_W(NODE_W), .NODE_ID(NODE_ID)) u_route (
    .clk     (clk),
    .rst     (rst),
    .in_busy (s_busy[S_RIN]),
    .fire    (s_fire[S_RIN]),
    .dest    (rin_flit[DEST_HI -: NODE_W]),
    .route   (route)
  );

  assign tr_req = rin_valid && (route == RT_FORWARD);

  rbs_out_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .en        (mode_q),
    .tr_req    (tr_req),
    .loc_req   (inj_valid),
    .fire      (s_fire[S_ROUT]),
    .tail      (s_tail[S_ROUT]),
    .owner     (owner),
    .owner_nxt (owner_nxt)
  );

  // Mode follows dark_req only at a boundary on every stream (R8).
  assign quiet = (s_busy_d == '0) && (owner_nxt == OWN_NONE);

  always_ff @(posedge clk) begin
    if (rst)        mode_q <= 1'b0;
    else if (quiet) mode_q <= dark_req;
  end

  assign rtr_rin_flit = rin_flit;
  assign rtr_inj_flit = inj_flit;

  always_comb begin
    if (!mode_q) begin
      rtr_rin_valid  = rin_valid;
      rin_ready      = rtr_rin_ready;
      rout_valid     = rtr_rout_valid;
      rout_flit      = rtr_rout_flit;
      rtr_rout_ready = rout_ready;
      rtr_inj_valid  = inj_valid;
      inj_ready      = rtr_inj_ready;
      ej_valid       = rtr_ej_valid;
      ej_flit        = rtr_ej_flit;
      rtr_ej_ready   = ej_ready;
    end else begin
      rtr_rin_valid  = 1'b0;
      rtr_rout_ready = 1'b0;
      rtr_inj_valid  = 1'b0;
      rtr_ej_ready   = 1'b0;
      ej_valid       = rin_valid && (route == RT_EJECT);
      ej_flit        = rin_flit;
      rin_ready      = (route == RT_EJECT) ? ej_ready
                                           : ((owner == OWN_TRANSIT) && rout_ready);
      rout_valid     = (owner == OWN_TRANSIT) ? rin_valid
                     : (owner == OWN_LOCAL)   ? inj_valid : 1'b0;
      rout_flit      = (owner == OWN_LOCAL) ? inj_flit : rin_flit;
      inj_ready      = (owner == OWN_LOCAL) && rout_ready;
    end
  end

endmodule

// File: rtl/ring_bypass_steer_chk.sv
module ring_bypass_steer_chk #(
  parameter int NODE_W = 3,
  parameter int DATA_W = 8,
  localparam int FLIT_W = 2 + NODE_W + DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_q,
  input logic              quiet,
  input logic              rin_valid,
  input logic [FLIT_W-1:0] rin_flit,
  input logic              rin_ready,
  input logic              rout_valid,
  input logic [FLIT_W-1:0] rout_flit,
  input logic              rout_ready,
  input logic              ej_valid,
  input logic [FLIT_W-1:0] ej_flit,
  input logic              ej_ready,
  input logic              rtr_rin_valid,
  input logic              rtr_rin_ready,
  input logic              rtr_rout_ready,
  input logic              rtr_inj_valid,
  input logic              rtr_ej_ready
);

  p_dark_router_r8: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> (!rtr_rin_valid && !rtr_inj_valid && !rtr_rout_ready && !rtr_ej_ready));

  p_switch_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(quiet));

  p_eject_source_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q && ej_valid) |-> (rin_valid && ej_flit == rin_flit));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rout_valid && !rout_ready) |=>
      ((rout_valid && $stable(rout_flit)) || (mode_q != $past(mode_q))));

  p_router_pass_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (rtr_rin_valid == rin_valid && rin_ready == rtr_rin_ready));

  p_ready_path_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q && ej_valid) |-> (rin_ready == ej_ready));

endmodule

bind ring_bypass_steer ring_bypass_steer_chk #(.NODE_W(NODE_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mode_q         (mode_q),
  .quiet          (quiet),
  .rin_valid      (rin_valid),
  .rin_flit       (rin_flit),
  .rin_ready      (rin_ready),
  .rout_valid     (rout_valid),
  .rout_flit      (rout_flit),
  .rout_ready     (rout_ready),
  .ej_valid       (ej_valid),
  .ej_flit        (ej_flit),
  .ej_ready       (ej_ready),
  .rtr_rin_valid  (rtr_rin_valid),
  .rtr_rin_ready  (rtr_rin_ready),
  .rtr_rout_ready (rtr_rout_ready),
  .rtr_inj_valid  (rtr_inj_valid),
  .rtr_ej_ready   (rtr_ej_ready)
);

// File: tb/ring_bypass_steer_test.sv
module ring_bypass_steer_test;

  localparam int NODE_W  = 3;
  localparam int DATA_W  = 8;
  localparam int NODE_ID = 5;
  localparam int FW      = 2 + NODE_W + DATA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          dark_req = 1'b0;
  logic          rin_valid = 1'b0;
  logic [FW-1:0] rin_flit = '0;
  logic          rin_ready;
  logic          rout_valid;
  logic [FW-1:0] rout_flit;
  logic          rout_ready = 1'b0;
  logic          inj_valid = 1'b0;
  logic [FW-1:0] inj_flit = '0;
  logic          inj_ready;
  logic          ej_valid;
  logic [FW-1:0] ej_flit;
  logic          ej_ready = 1'b0;
  logic          rtr_rin_valid;
  logic [FW-1:0] rtr_rin_flit;
  logic          rtr_rin_ready = 1'b0;
  logic          rtr_rout_valid = 1'b0;
  logic [FW-1:0] rtr_rout_flit = '0;
  logic          rtr_rout_ready;
  logic          rtr_inj_valid;
  logic [FW-1:0] rtr_inj_flit;
  logic          rtr_inj_ready = 1'b0;
  logic          rtr_ej_valid = 1'b0;
  logic [FW-1:0] rtr_ej_flit = '0;
  logic          rtr_ej_ready;

  ring_bypass_steer #(.NODE_W(NODE_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID)) uut (
    .clk(clk), .rst(rst), .dark_req(dark_req),
    .rin_valid(rin_valid), .rin_flit(rin_flit), .rin_ready(rin_ready),
    .rout_valid(rout_valid), .rout_flit(rout_flit), .rout_ready(rout_ready),
    .inj_valid(inj_valid), .inj_flit(inj_flit), .inj_ready(inj_ready),
    .ej_valid(ej_valid), .ej_flit(ej_flit), .ej_ready(ej_ready),
    .rtr_rin_valid(rtr_rin_valid), .rtr_rin_flit(rtr_rin_flit), .rtr_rin_ready(rtr_rin_ready),
    .rtr_rout_valid(rtr_rout_valid), .rtr_rout_flit(rtr_rout_flit), .rtr_rout_ready(rtr_rout_ready),
    .rtr_inj_valid(rtr_inj_valid), .rtr_inj_flit(rtr_inj_flit), .rtr_inj_ready(rtr_inj_ready),
    .rtr_ej_valid(rtr_ej_valid), .rtr_ej_flit(rtr_ej_flit), .rtr_ej_ready(rtr_ej_ready)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit steer_model = 1'b0;  // bench's own view of the mode
  bit stall_en = 1'b0;
  bit manual = 1'b1;

  // Expected queues per output: 0 ejection, 1 ring out, 2 router ring in, 3 router local in.
  logic [FW-1:0] q_ej[$];
  logic [FW-1:0] q_rout[$];
  logic [FW-1:0] q_rrin[$];
  logic [FW-1:0] q_rinj[$];

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic check(input bit ok, input string tag, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input bit hd, input bit tl,
                                       input logic [NODE_W-1:0] d, input logic [DATA_W-1:0] p);
    return {hd, tl, d, p};
  endfunction

  // Output index from input port and destination, per R2..R5.
  function automatic int dest_out(input int port, input logic [NODE_W-1:0] d);
    case (port)
      0:       return steer_model ? ((d == NODE_ID[NODE_W-1:0]) ? 0 : 1) : 2;
      1:       return steer_model ? 1 : 3;
      2:       return 1;
      default: return 0;
    endcase
  endfunction

  task automatic push_exp(input int o, input logic [FW-1:0] f);
    case (o)
      0: q_ej.push_back(f);
      1: q_rout.push_back(f);
      2: q_rrin.push_back(f);
      default: q_rinj.push_back(f);
    endcase
  endtask

  task automatic set_src(input int port, input bit v, input logic [FW-1:0] f);
    case (port)
      0: begin rin_valid = v; rin_flit = f; end
      1: begin inj_valid = v; inj_flit = f; end
      2: begin rtr_rout_valid = v; rtr_rout_flit = f; end
      default: begin rtr_ej_valid = v; rtr_ej_flit = f; end
    endcase
  endtask

  function automatic bit src_ready(input int port);
    case (port)
      0: return rin_ready;
      1: return inj_ready;
      2: return rtr_rout_ready;
      default: return rtr_ej_ready;
    endcase
  endfunction

  // Driver: ports 0 ring in, 1 injection, 2 router ring out, 3 router local out.
  task automatic send_pkt(input int port, input logic [NODE_W-1:0] d, input int len,
                          input logic [DATA_W-1:0] base, input bit push);
    for (int i = 0; i < len; i++) begin
      logic [FW-1:0] f;
      bit r;
      f = mk(i == 0, i == len - 1, d, base + DATA_W'(i));
      if (push) push_exp(dest_out(port, d), f);
      @(negedge clk);
      set_src(port, 1'b1, f);
      forever begin
        #1 r = src_ready(port);
        @(posedge clk);
        if (r) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    set_src(port, 1'b0, '0);
  endtask

  // Sink readiness pattern.
  always @(negedge clk) begin
    cyc++;
    if (!manual) begin
      ej_ready      = !stall_en || (cyc % 3 == 0);
      rout_ready    = !stall_en || (cyc % 3 == 1);
      rtr_rin_ready = !stall_en || (cyc % 3 == 2);
      rtr_inj_ready = !stall_en || (cyc % 3 == 0);
    end
  end

  // Monitor: compare each accepted output flit with the scoreboard.
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (ej_valid && ej_ready) begin
        if (q_ej.size() == 0) check(1'b0, "R3 unexpected ejection", ej_flit, '0);
        else begin logic [FW-1:0] e; e = q_ej.pop_front(); check(ej_flit == e, "R3 ejection flit", ej_flit, e); end
      end
      if (rout_valid && rout_ready) begin
        if (q_rout.size() == 0) check(1'b0, "R4 unexpected ring output", rout_flit, '0);
        else begin logic [FW-1:0] e; e = q_rout.pop_front(); check(rout_flit == e, "R4 R5 R6 ring output flit", rout_flit, e); end
      end
      if (rtr_rin_valid && rtr_rin_ready) begin
        if (q_rrin.size() == 0) check(1'b0, "R2 unexpected router ring input", rtr_rin_flit, '0);
        else begin logic [FW-1:0] e; e = q_rrin.pop_front(); check(rtr_rin_flit == e, "R2 router ring input flit", rtr_rin_flit, e); end
      end
      if (rtr_inj_valid && rtr_inj_ready) begin
        if (q_rinj.size() == 0) check(1'b0, "R2 unexpected router local input", rtr_inj_flit, '0);
        else begin logic [FW-1:0] e; e = q_rinj.pop_front(); check(rtr_inj_flit == e, "R2 router local input flit", rtr_inj_flit, e); end
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 100000);
      summary();
      $finish;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while ((q_ej.size() + q_rout.size() + q_rrin.size() + q_rinj.size()) != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    dark_req = m;
    wait_cycles(3);
    steer_model = m;
  endtask

  initial begin
    wait_cycles(3);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state, router mode, nothing valid on outputs.
    check(!ej_valid && !rout_valid && !rtr_rin_valid, "R1 reset outputs idle",
          {ej_valid, rout_valid, rtr_rin_valid}, '0);
    @(negedge clk);
    rin_valid = 1'b1;
    rin_flit  = mk(1, 1, NODE_ID[NODE_W-1:0], 8'h11);
    #1;
    check(rtr_rin_valid && !ej_valid && !rout_valid, "R1 local-dest flit goes to router after reset",
          {rtr_rin_valid, ej_valid, rout_valid}, 3'b100);
    rin_valid = 1'b0;
    manual = 1'b0;
    stall_en = 1'b1;

    // R2: router mode pass-through on all four paths.
    send_pkt(0, 3'd2, 3, 8'h20, 1'b1);
    send_pkt(1, 3'd4, 2, 8'h30, 1'b1);
    send_pkt(2, 3'd1, 2, 8'h40, 1'b1);
    send_pkt(3, NODE_ID[NODE_W-1:0], 2, 8'h50, 1'b1);
    drain();

    // Enter steering mode at a boundary.
    set_mode(1'b1);
    @(negedge clk);
    rin_valid = 1'b1;
    inj_valid = 1'b1;
    rin_flit  = mk(1, 0, 3'd2, 8'h00);
    #1;
    check(!rtr_rin_valid && !rtr_inj_valid && !rtr_rout_ready && !rtr_ej_ready,
          "R8 router side dark in steering mode",
          {rtr_rin_valid, rtr_inj_valid, rtr_rout_ready, rtr_ej_ready}, '0);
    rin_valid = 1'b0;
    inj_valid = 1'b0;

    // R3, R4, R5, R10 in steering mode.
    send_pkt(0, NODE_ID[NODE_W-1:0], 3, 8'h60, 1'b1);
    send_pkt(0, 3'd1, 4, 8'h70, 1'b1);
    send_pkt(1, 3'd7, 3, 8'h80, 1'b1);
    send_pkt(0, NODE_ID[NODE_W-1:0], 1, 8'h90, 1'b1);
    send_pkt(0, 3'd3, 1, 8'h98, 1'b1);
    drain();

    // R7 and R6: both request together, transit first and not interleaved.
    for (int i = 0; i < 3; i++) q_rout.push_back(mk(i == 0, i == 2, 3'd0, 8'hA0 + 8'(i)));
    for (int i = 0; i < 3; i++) q_rout.push_back(mk(i == 0, i == 2, 3'd6, 8'hB0 + 8'(i)));
    fork
      send_pkt(0, 3'd0, 3, 8'hA0, 1'b0);
      send_pkt(1, 3'd6, 3, 8'hB0, 1'b0);
    join
    drain();

    // R6: local owns the output first; transit arriving later waits for its tail.
    for (int i = 0; i < 3; i++) q_rout.push_back(mk(i == 0, i == 2, 3'd6, 8'hC0 + 8'(i)));
    for (int i = 0; i < 2; i++) q_rout.push_back(mk(i == 0, i == 1, 3'd2, 8'hD0 + 8'(i)));
    fork
      send_pkt(1, 3'd6, 3, 8'hC0, 1'b0);
      begin @(negedge clk); send_pkt(0, 3'd2, 2, 8'hD0, 1'b0); end
    join
    drain();

    // R9: ready tracks the selected sink in the same cycle.
    manual = 1'b1;
    @(negedge clk);
    ej_ready  = 1'b0;
    rin_valid = 1'b1;
    rin_flit  = mk(1, 1, NODE_ID[NODE_W-1:0], 8'hE0);
    #1;
    check(rin_ready == 1'b0, "R9 rin_ready low with ej_ready low", {12'd0, rin_ready}, '0);
    ej_ready = 1'b1;
    q_ej.push_back(rin_flit);
    #1;
    check(rin_ready == 1'b1, "R9 rin_ready follows ej_ready", {12'd0, rin_ready}, 1);
    @(negedge clk);
    rin_valid = 1'b0;
    manual = 1'b0;
    drain();

    // R8: leave steering mode requested mid-packet; the packet completes on the old path.
    fork
      send_pkt(0, NODE_ID[NODE_W-1:0], 4, 8'hF0, 1'b1);
      begin wait_cycles(3); dark_req = 1'b0; end
    join
    drain();
    wait_cycles(3);
    steer_model = 1'b0;
    send_pkt(0, NODE_ID[NODE_W-1:0], 2, 8'h05, 1'b1);
    send_pkt(1, 3'd3, 1, 8'h0A, 1'b1);
    drain();

    check(q_ej.size() == 0, "R3 ejection queue empty", FW'(q_ej.size()), '0);
    check(q_rout.size() == 0, "R4 ring output queue empty", FW'(q_rout.size()), '0);
    check(q_rrin.size() == 0, "R2 router ring input queue empty", FW'(q_rrin.size()), '0);
    check(q_rinj.size() == 0, "R2 router local input queue empty", FW'(q_rinj.size()), '0);
    summary();
    $finish;
  end

endmodule